// File: doc/BRIEF.md
# Pin-Triggered User RAM Clear Controller

This block erases a small user RAM on demand from an external, active-low clear pin. When the clear function is armed, a falling edge on the pin starts a hardware sweep. The sweep writes the fill value 0xFF into every user byte, one byte per clock, through a byte-wide RAM write port. The block drives only that port. Any timekeeping state and any larger external memory stay outside its reach, so the sweep cannot disturb them.

When the sweep completes, a done flag is raised. An interrupt is requested only if main supply is present and the interrupt is enabled at that moment. Software clears the flag by writing 0 to it. The interrupt line releases once no other source is holding it. From the start of a clear, a lockout output blocks host read and write cycles. It stays high for at least a programmable recovery time and for as long as the sweep runs.

The pin is taken through a synchroniser before its edges are detected. Falling edges that arrive while a lockout is in force are discarded.

Top module: `ram_clear_ctrl`

## Requirements
- R1: After reset, ram_we_o is 0, flag_o is 0, irq_no is 1 and lockout_o is 0.
- R2: With clr_en_i = 1, a falling edge on clr_pin_ni gives its first RAM write 3 clock edges after the pin is sampled low. The sweep then writes 0xFF to addresses 0, 1, … WORDS-1, in ascending order, one address per clock, with no gaps.
- R3: With clr_en_i = 0, a falling edge on clr_pin_ni produces no RAM write, leaves flag_o unchanged and does not raise lockout_o.
- R4: flag_o goes to 1 on the same clock edge on which the last write of the sweep completes, which is also the edge on which ram_we_o drops. It stays 0 before that edge.
- R5: At sweep completion, irq_no goes low only if both vcc_ok_i = 1 and irq_en_i = 1. Otherwise irq_no stays high, although flag_o is still set.
- R6: A host write (flag_wr_i = 1) with flag_wdata_i = 0 clears flag_o and this block's interrupt request. irq_no stays low while other_irq_i = 1. A write of 1 has no effect.
- R7: lockout_o rises with the first write cycle. It stays high for max(RECOVERY_CYCLES, WORDS) cycles, and ram_we_o is never high without lockout_o.
- R8: A falling edge on the pin while lockout_o is high, whether during the sweep or during the remaining recovery time, starts nothing: no extra writes appear.
- R9: Every write address lies in 0..WORDS-1, and each sweep issues exactly WORDS writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_pin_ni | input | 1 | External clear pin, active low, asynchronous |
| clr_en_i | input | 1 | Clear function enable |
| irq_en_i | input | 1 | Completion interrupt enable |
| vcc_ok_i | input | 1 | Main supply present |
| flag_wr_i | input | 1 | Host write strobe to the done flag |
| flag_wdata_i | input | 1 | Value written to the done flag (0 clears) |
| other_irq_i | input | 1 | Another interrupt source is pending |
| ram_we_o | output | 1 | User RAM write enable |
| ram_addr_o | output | $clog2(WORDS) | User RAM write address |
| ram_wdata_o | output | DW | User RAM write data (fill value) |
| flag_o | output | 1 | Clear-done flag |
| irq_no | output | 1 | Interrupt request, active low |
| lockout_o | output | 1 | Host access lockout |

## Verification
The bench builds the block with WORDS = 114 and RECOVERY_CYCLES = 200. This makes the recovery window outlast the 114-cycle sweep. The lockout length can then be told apart from the sweep length, and a pin edge can be placed after the sweep but still inside the lockout. Keeping the full 114-byte depth means the last-address completion, the flag timing and the all-ones content of every byte are all checked at the real size.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/rc_pin_sync.sv
module rc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its previous value
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-1:0], pin_i};
  end

  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/rc_sweep.sv
module rc_sweep
  import rc_pkg::*;
#(
  parameter int          WORDS = 114,
  parameter int          DW    = 8,
  parameter logic [DW-1:0] FILL = '1,
  localparam int         AW    = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          active_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  sweep_state_e state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SWEEP;
        addr_d  = '0;
      end
      ST_SWEEP: begin
        if (addr_q == LAST) state_d = ST_IDLE;
        else                addr_d  = addr_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  assign we_o     = (state_q == ST_SWEEP);
  assign active_o = we_o;
  assign addr_o   = addr_q;
  assign data_o   = FILL;
  assign done_o   = we_o && (addr_q == LAST);

  p_addr_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (int'(addr_o) < WORDS));
  p_ascending_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && $past(we_o)) |-> (addr_o == $past(addr_o) + 1'b1));
  p_first_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_o) |-> (addr_o == '0));
endmodule

// File: rtl/rc_lock_timer.sv
module rc_lock_timer #(
  parameter int RECOVERY_CYCLES = 16,
  localparam int CW = $clog2(RECOVERY_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sweep_active_i,
  output logic lock_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= CW'(RECOVERY_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign lock_o = (cnt_q != '0) | sweep_active_i;

  p_lock_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> lock_o);
endmodule

// File: rtl/rc_flag_irq.sv
module rc_flag_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic vcc_ok_i,
  input  logic irq_en_i,
  input  logic flag_wr_i,
  input  logic flag_wdata_i,
  input  logic other_irq_i,
  output logic flag_o,
  output logic irq_no
);
  logic flag_q, req_q;
  logic clr;

  assign clr = flag_wr_i & ~flag_wdata_i;

  // completion has priority over a simultaneous host clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else if (done_i) begin
      flag_q <= 1'b1;
      req_q  <= vcc_ok_i & irq_en_i;
    end else if (clr) begin
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_no = ~(req_q | other_irq_i);

  p_flag_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> flag_o);
  p_irq_needs_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !other_irq_i) |-> flag_o);
  p_flag_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !done_i) |=> !flag_o);
endmodule

// File: rtl/ram_clear_ctrl.sv
module ram_clear_ctrl #(
  parameter int WORDS           = 114,
  parameter int DW              = 8,
  parameter int RECOVERY_CYCLES = 16,
  parameter int SYNC_STAGES     = 2,
  localparam int AW             = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_pin_ni,
  input  logic          clr_en_i,
  input  logic          irq_en_i,
  input  logic          vcc_ok_i,
  input  logic          flag_wr_i,
  input  logic          flag_wdata_i,
  input  logic          other_irq_i,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic          flag_o,
  output logic          irq_no,
  output logic          lockout_o
);
  logic pin_fall, start, sweep_active, sweep_done;

  rc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (clr_pin_ni),
    .fall_o(pin_fall)
  );

  // edges during lockout are dropped
  assign start = pin_fall & clr_en_i & ~lockout_o;

  rc_sweep #(.WORDS(WORDS), .DW(DW), .FILL('1)) u_sweep (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .we_o    (ram_we_o),
    .addr_o  (ram_addr_o),
    .data_o  (ram_wdata_o),
    .active_o(sweep_active),
    .done_o  (sweep_done)
  );

  rc_lock_timer #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) u_lock (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .sweep_active_i(sweep_active),
    .lock_o        (lockout_o)
  );

  rc_flag_irq u_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (sweep_done),
    .vcc_ok_i    (vcc_ok_i),
    .irq_en_i    (irq_en_i),
    .flag_wr_i   (flag_wr_i),
    .flag_wdata_i(flag_wdata_i),
    .other_irq_i (other_irq_i),
    .flag_o      (flag_o),
    .irq_no      (irq_no)
  );

  p_we_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> lockout_o);
  p_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_fall && !clr_en_i && !lockout_o) |=> !ram_we_o);
  p_done_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ram_we_o) |-> (flag_o && !$past(flag_o)));
endmodule

// File: tb/ram_clear_ctrl_bench.sv
module ram_clear_ctrl_bench;
  localparam int WORDS = 114;
  localparam int DW    = 8;
  localparam int REC   = 200;
  localparam int AW    = $clog2(WORDS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1, en = 1'b0, ie = 1'b0, vcc = 1'b1;
  logic fwr = 1'b0, fwd = 1'b0, oirq = 1'b0;
  logic we, flag, irq_n, lock;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;

  always #10 clk = ~clk;

  ram_clear_ctrl #(.WORDS(WORDS), .DW(DW), .RECOVERY_CYCLES(REC)) u_ram_clear_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .clr_pin_ni(pin), .clr_en_i(en), .irq_en_i(ie),
    .vcc_ok_i(vcc), .flag_wr_i(fwr), .flag_wdata_i(fwd), .other_irq_i(oirq),
    .ram_we_o(we), .ram_addr_o(addr), .ram_wdata_o(wdata), .flag_o(flag),
    .irq_no(irq_n), .lockout_o(lock)
  );

  int errors = 0, checks = 0;
  int wr_cnt = 0, lock_cycles = 0;
  int exp_q[$];
  logic [DW-1:0] mem [WORDS];
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: pops expected writes and models the RAM
  always @(negedge clk) begin
    if (rst_n) begin
      if (lock) lock_cycles++;
      if (we) begin
        wr_cnt++;
        if (int'(addr) < WORDS) mem[addr] = wdata;
        if (exp_q.size() == 0) check(1'b0, "R8", "unexpected write addr", int'(addr), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(int'(addr) == e, "R9", "write address", int'(addr), e);
          check(wdata == 8'hFF, "R2", "write data", int'(wdata), 255);
        end
      end
    end
  end

  task automatic prefill();
    for (int i = 0; i < WORDS; i++) mem[i] = DW'(i) ^ 8'h5A;
  endtask

  task automatic write_flag(input logic v);
    @(negedge clk); fwr = 1'b1; fwd = v;
    @(negedge clk); fwr = 1'b0;
  endtask

  // mode: 0 plain, 1 extra edge during sweep, 2 extra edge during recovery
  task automatic run_clear(input int mode);
    int w0;
    prefill();
    w0 = wr_cnt;
    for (int i = 0; i < WORDS; i++) exp_q.push_back(i);
    @(negedge clk); lock_cycles = 0; pin = 1'b0;
    @(negedge clk); check(we == 1'b0, "R2", "we before latency", int'(we), 0);
    @(negedge clk); check(we == 1'b0, "R2", "we before latency", int'(we), 0);
    @(negedge clk); check(we == 1'b1, "R2", "we at latency 3", int'(we), 1);
    check(lock == 1'b1, "R7", "lockout with first write", int'(lock), 1);
    repeat (3) @(negedge clk);
    pin = 1'b1;
    repeat (30) @(negedge clk);
    if (mode == 1) begin
      pin = 1'b0; repeat (4) @(negedge clk); pin = 1'b1;
    end
    while (we) begin
      check(flag == 1'b0, "R4", "flag during sweep", int'(flag), 0);
      @(negedge clk);
    end
    check(flag == 1'b1, "R4", "flag when we drops", int'(flag), 1);
    check(wr_cnt - w0 == WORDS, "R9", "write count", wr_cnt - w0, WORDS);
    if (mode == 2) begin
      repeat (20) @(negedge clk);
      check(lock == 1'b1, "R7", "lockout after sweep", int'(lock), 1);
      pin = 1'b0; repeat (4) @(negedge clk); pin = 1'b1;
    end
    repeat (REC) @(negedge clk);
    check(lock == 1'b0, "R7", "lockout released", int'(lock), 0);
    check(lock_cycles == REC, "R7", "lockout length", lock_cycles, REC);
    check(wr_cnt - w0 == WORDS, "R8", "no extra writes", wr_cnt - w0, WORDS);
    check(exp_q.size() == 0, "R9", "pending expected writes", exp_q.size(), 0);
    for (int i = 0; i < WORDS; i++)
      if (mem[i] != 8'hFF) check(1'b0, "R2", "ram byte not 0xFF", int'(mem[i]), 255);
    checks++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(we == 1'b0,   "R1", "reset we", int'(we), 0);
    check(flag == 1'b0, "R1", "reset flag", int'(flag), 0);
    check(irq_n == 1'b1,"R1", "reset irq_n", int'(irq_n), 1);
    check(lock == 1'b0, "R1", "reset lockout", int'(lock), 0);

    // R3: disabled, edge does nothing
    begin
      int w0;
      w0 = wr_cnt; lock_cycles = 0;
      pin = 1'b0; repeat (6) @(negedge clk); pin = 1'b1;
      repeat (20) @(negedge clk);
      check(wr_cnt == w0, "R3", "writes while disabled", wr_cnt - w0, 0);
      check(flag == 1'b0, "R3", "flag while disabled", int'(flag), 0);
      check(lock_cycles == 0, "R3", "lockout while disabled", lock_cycles, 0);
    end

    // R5: vcc and irq enable both set, extra edge in sweep (R8)
    en = 1'b1; ie = 1'b1; vcc = 1'b1;
    run_clear(1);
    check(irq_n == 1'b0, "R5", "irq asserted", int'(irq_n), 0);

    // R6: write 1 has no effect
    write_flag(1'b1);
    check(flag == 1'b1, "R6", "flag after write 1", int'(flag), 1);
    check(irq_n == 1'b0, "R6", "irq after write 1", int'(irq_n), 0);
    // R6: clear with another source pending
    oirq = 1'b1;
    write_flag(1'b0);
    check(flag == 1'b0, "R6", "flag cleared", int'(flag), 0);
    check(irq_n == 1'b0, "R6", "irq held by other source", int'(irq_n), 0);
    oirq = 1'b0;
    @(negedge clk);
    check(irq_n == 1'b1, "R6", "irq released", int'(irq_n), 1);

    // R5: irq disabled, extra edge in recovery (R8)
    ie = 1'b0;
    run_clear(2);
    check(irq_n == 1'b1, "R5", "irq with enable off", int'(irq_n), 1);
    write_flag(1'b0);
    check(flag == 1'b0, "R6", "flag cleared", int'(flag), 0);

    // R5: no supply
    ie = 1'b1; vcc = 1'b0;
    run_clear(0);
    check(irq_n == 1'b1, "R5", "irq without vcc", int'(irq_n), 1);
    check(flag == 1'b1, "R5", "flag without vcc", int'(flag), 1);

    // R3: disabled after a flagged run keeps flag
    en = 1'b0;
    begin
      int w0;
      w0 = wr_cnt;
      pin = 1'b0; repeat (6) @(negedge clk); pin = 1'b1;
      repeat (20) @(negedge clk);
      check(wr_cnt == w0, "R3", "writes while disabled", wr_cnt - w0, 0);
      check(flag == 1'b1, "R3", "flag kept while disabled", int'(flag), 1);
    end
    summary();
  end
endmodule